// File: doc/BRIEF.md
# Timer Underflow Interrupt Decimator

This block sits next to a periodic down-counting timer. It turns the timer's single-cycle underflow pulse into an interrupt request that fires only on every nth counted underflow. The divide value n is four bits wide and is loaded through a byte-wide write strobe. Only the low nibble of the written byte is kept. The block has no read path.

Two static mode inputs shape the counting. When the qualified-count mode is selected, an underflow counts only if an externally computed qualifying condition is true in the same cycle. Otherwise every underflow counts. When the early-first option is set, the first interrupt after a fresh count sequence comes one counted underflow sooner than usual, at n-1. Every later interrupt comes after n. With n equal to 1, the first interrupt still needs one counted underflow.

A run input gates counting. While run is low, underflows are ignored and the partial count is held. A write made while stopped clears the count and re-arms the early-first behaviour, so the next run starts cleanly. A write made while running changes only the divide value, and the underflow in that same cycle is judged against the old value. The timer, the condition logic and the bus decoder are outside this block.

Top module: `uf_irq_decimator`

## Requirements
- R1: After reset the stored divide value is 0 and irq is low.
- R2: With mode_qual=0, run=1 and a write made while stopped, irq pulses on the nth, 2nth, 3nth... underflow for every n from 1 to 15.
- R3: With mode_qual=1, an underflow counts only when qual_ok=1 in the same cycle. irq pulses on every nth counted underflow and is never high when qual_ok is low.
- R4: With early_first=1, the first irq of a fresh sequence comes on counted underflow max(n-1,1), and later irqs come every n counted underflows.
- R5: irq is combinational. It is high only in the cycle of the counted underflow that completes the count, so it never rises without uf_pulse and run both high.
- R6: While run=0, underflows produce no irq and leave the partial count unchanged. The count resumes from that value once run returns to 1.
- R7: A write while run=0 clears the count to zero and re-arms the early-first behaviour.
- R8: Only bits [3:0] of wr_data set the divide value. Bits [7:4] are ignored.
- R9: When a write lands in the same cycle as a counted underflow while running, that underflow is compared against the old n. The new n applies from the next cycle, and the count is not cleared.
- R10: While the divide value is 0, no irq is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the divide value |
| wr_data | input | 8 | Write data; bits [3:0] hold n |
| run | input | 1 | 1 = counter running, 0 = stopped |
| mode_qual | input | 1 | 1 = count only qualified underflows |
| early_first | input | 1 | 1 = first interrupt after n-1 counts |
| uf_pulse | input | 1 | Timer underflow, one cycle wide |
| qual_ok | input | 1 | Qualifying condition for the current underflow |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong count or a stale first-interrupt flag shifts the phase of irq. The error appears at the port on the very next interrupt, no more than fifteen counted underflows later, and it keeps the wrong phase for the rest of the run. For that reason the bench compares irq against an arithmetic model on every cycle, across all divide values, both count modes and both first-interrupt options. Directed cases cover four situations that would otherwise stay hidden: a held count across a stop, a reload on a stopped write, a write colliding with an underflow, and a zero divide value.

// File: rtl/ufd_pkg.sv
package ufd_pkg;
    localparam int DIV_W  = 4;
    localparam int DATA_W = 8;
endpackage

// File: rtl/ufd_qualifier.sv
module ufd_qualifier (
    input  logic run,
    input  logic mode_qual,
    input  logic uf_pulse,
    input  logic qual_ok,
    output logic count_en
);
    always_comb begin
        count_en = run & uf_pulse & (~mode_qual | qual_ok);
    end
endmodule

// File: rtl/ufd_cfg_reg.sv
module ufd_cfg_reg #(
    parameter int DATA_W = ufd_pkg::DATA_W,
    parameter int DIV_W  = ufd_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q
);
    logic [DIV_W-1:0] div_d;

    always_comb begin
        div_d = div_q;
        if (wr_en) begin
            div_d = wr_data[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/ufd_counter.sv
module ufd_counter #(
    parameter int DIV_W = ufd_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             reload,
    input  logic             early_en,
    input  logic [DIV_W-1:0] div,
    output logic             irq,
    output logic [DIV_W-1:0] cnt
);
    localparam int SUM_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             first;
    } state_t;

    state_t           st_d, st_q;
    logic [DIV_W-1:0] target;
    logic [SUM_W-1:0] next_cnt;
    logic             irq_c;

    always_comb begin
        st_d     = st_q;
        irq_c    = 1'b0;
        target   = (st_q.first && early_en && (div > DIV_W'(1))) ? div - DIV_W'(1) : div;
        next_cnt = {1'b0, st_q.cnt} + SUM_W'(1);
        if (reload) begin
            st_d.cnt   = '0;
            st_d.first = 1'b1;
        end else if (count_en && (div != '0)) begin
            if (next_cnt >= {1'b0, target}) begin
                irq_c      = 1'b1;
                st_d.cnt   = '0;
                st_d.first = 1'b0;
            end else begin
                st_d.cnt = next_cnt[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, first: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = irq_c;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/uf_irq_decimator.sv
module uf_irq_decimator #(
    parameter int DATA_W = ufd_pkg::DATA_W,
    parameter int DIV_W  = ufd_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              run,
    input  logic              mode_qual,
    input  logic              early_first,
    input  logic              uf_pulse,
    input  logic              qual_ok,
    output logic              irq
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             count_en;
    logic             reload;

    assign reload = wr_en & ~run;

    ufd_qualifier u_qual (
        .run      (run),
        .mode_qual(mode_qual),
        .uf_pulse (uf_pulse),
        .qual_ok  (qual_ok),
        .count_en (count_en)
    );

    ufd_cfg_reg #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .div_q  (div_q)
    );

    ufd_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(count_en),
        .reload  (reload),
        .early_en(early_first),
        .div     (div_q),
        .irq     (irq),
        .cnt     (cnt_q)
    );
endmodule

// File: rtl/ufd_checker.sv
module ufd_checker #(
    parameter int DIV_W = ufd_pkg::DIV_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             run,
    input logic             mode_qual,
    input logic             uf_pulse,
    input logic             qual_ok,
    input logic             irq,
    input logic [DIV_W-1:0] div,
    input logic [DIV_W-1:0] cnt
);
    p_irq_on_uf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (uf_pulse && run));

    p_qual_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode_qual) |-> qual_ok);

    p_zero_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !irq);

    p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(cnt));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !run) |=> (cnt == '0));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '1);
endmodule

bind uf_irq_decimator ufd_checker #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .run      (run),
    .mode_qual(mode_qual),
    .uf_pulse (uf_pulse),
    .qual_ok  (qual_ok),
    .irq      (irq),
    .div      (div_q),
    .cnt      (cnt_q)
);

// File: tb/tb_uf_irq_decimator.sv
`timescale 1ns/1ps
module tb_uf_irq_decimator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       run = 1'b0;
    logic       mode_qual = 1'b0;
    logic       early_first = 1'b0;
    logic       uf_pulse = 1'b0;
    logic       qual_ok = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    uf_irq_decimator dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .run(run), .mode_qual(mode_qual), .early_first(early_first),
        .uf_pulse(uf_pulse), .qual_ok(qual_ok), .irq(irq)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic write_div(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic set_run(input logic v);
        @(negedge clk);
        run = v;
        @(posedge clk);
        #1;
    endtask

    task automatic tick(input logic u, input logic q, input logic exp, input string tag);
        @(negedge clk);
        uf_pulse = u;
        qual_ok = q;
        #3 check(irq, exp, tag);
        @(posedge clk);
        #1 uf_pulse = 1'b0;
        qual_ok = 1'b0;
    endtask

    function automatic logic fires(input int k, input int n, input logic early);
        int f1;
        f1 = early ? ((n > 1) ? n - 1 : 1) : n;
        return (k >= f1) && (((k - f1) % n) == 0);
    endfunction

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: irq=x expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #10 check(irq, 1'b0, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        #1 check(irq, 1'b0, "R1 after reset");

        // R10 and R1: divide value 0 after reset gives no interrupt
        set_run(1'b1);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b1, 1'b0, "R10 zero divide");
        set_run(1'b0);

        // R2, R3, R4: sweep all divide values and modes
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 2; e++) begin
                for (int n = 1; n <= 15; n++) begin
                    int k;
                    string tag;
                    k = 0;
                    tag = (e == 1) ? "R4 early sweep" : ((m == 1) ? "R3 qualified sweep" : "R2 plain sweep");
                    set_run(1'b0);
                    @(negedge clk);
                    mode_qual = m[0];
                    early_first = e[0];
                    write_div(8'(n));
                    set_run(1'b1);
                    for (int i = 0; i < 130; i++) begin
                        logic u, q, c, ex;
                        u = (i % 3) != 1;
                        q = (i % 5) < 3;
                        c = u && ((m == 0) || q);
                        if (c) k++;
                        ex = c && fires(k, n, e[0]);
                        tick(u, q, ex, tag);
                    end
                end
            end
        end

        // R5: no underflow, no interrupt even with qualifier high
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, "R5 no underflow");

        // R6: stopped counter holds its partial count
        set_run(1'b0);
        @(negedge clk);
        mode_qual = 1'b0;
        early_first = 1'b0;
        write_div(8'd3);
        set_run(1'b1);
        tick(1'b1, 1'b0, 1'b0, "R6 count 1");
        tick(1'b1, 1'b0, 1'b0, "R6 count 2");
        set_run(1'b0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, "R6 stopped");
        set_run(1'b1);
        tick(1'b1, 1'b0, 1'b1, "R6 resume completes");

        // R7: stopped write reloads and re-arms early first
        set_run(1'b0);
        @(negedge clk) early_first = 1'b1;
        write_div(8'd5);
        set_run(1'b1);
        for (int i = 1; i <= 4; i++) tick(1'b1, 1'b0, i == 4, "R7 first early");
        tick(1'b1, 1'b0, 1'b0, "R7 after first");
        tick(1'b1, 1'b0, 1'b0, "R7 after first");
        set_run(1'b0);
        write_div(8'd5);
        set_run(1'b1);
        for (int i = 1; i <= 4; i++) tick(1'b1, 1'b0, i == 4, "R7 reload rearm");
        for (int i = 1; i <= 5; i++) tick(1'b1, 1'b0, i == 5, "R7 steady n");

        // R8: upper data bits ignored (0xF3 gives n=3)
        set_run(1'b0);
        @(negedge clk) early_first = 1'b0;
        write_div(8'hF3);
        set_run(1'b1);
        for (int i = 1; i <= 6; i++) tick(1'b1, 1'b0, (i % 3) == 0, "R8 high bits");

        // R9: write colliding with counted underflow uses old n
        set_run(1'b0);
        write_div(8'd4);
        set_run(1'b1);
        tick(1'b1, 1'b0, 1'b0, "R9 count 1");
        tick(1'b1, 1'b0, 1'b0, "R9 count 2");
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'd2;
        uf_pulse = 1'b1;
        #3 check(irq, 1'b0, "R9 collision uses old n");
        @(posedge clk);
        #1 wr_en = 1'b0;
        uf_pulse = 1'b0;
        tick(1'b1, 1'b0, 1'b1, "R9 new n applies");
        tick(1'b1, 1'b0, 1'b0, "R9 new n period");
        tick(1'b1, 1'b0, 1'b1, "R9 new n period");

        // R10: writing zero while running stops interrupts
        write_div(8'h00);
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0, "R10 zero written");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule